// File: doc/BRIEF.md
# Wiper Tap Selector with Shutdown

This block drives the switch enables of a 128-position resistor string. It turns a stored 7-bit wiper code into one-hot tap enables. It also drives an enable for the string's high-end connection and an enable for the resistor that pulls the wiper to the low end. Tap changes are make-before-break: the switch for the new tap closes, both stay closed for a programmable number of cycles, and only then does the old switch open.

A load strobe, produced when a serial write completes, carries a code and a run bit. With the run bit low, the block enters shutdown. In shutdown the high end is disconnected, every tap is opened and the wiper is tied to the low end through the shutdown resistor, while the stored code is kept. A later load with the run bit high starts a recall period, and after it the stored tap closes again. The code returns to mid-scale at reset. It also returns to mid-scale if the supply-low flag stays asserted for a minimum run of consecutive cycles while the block is in shutdown.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: After reset, only tap enable bit 64 (mid-scale) is high, `high_conn_o` is 1 and `shdn_res_o` is 0.
- R2: Tap enable bit k corresponds to wiper code k, with bit 0 nearest the low end and bit 127 nearest the high end. A load with `run_i`=1 and a code that differs from the stored one is sampled at clock edge E. From edge E+2, the new and old tap bits are both high for MOVE_CYC cycles. From edge E+2+MOVE_CYC, only the new bit is high.
- R3: A load with `run_i`=1 and a code equal to the stored one keeps a single tap enabled, with no overlap period.
- R4: Without a load strobe, changes on `code_i` and `run_i` have no effect on any output.
- R5: A load with `run_i`=0 drives all tap enables to 0, `high_conn_o` to 0 and `shdn_res_o` to 1 from edge E+2. Its `code_i` is ignored, and further loads with `run_i`=0 during shutdown are ignored.
- R6: A load with `run_i`=1 during shutdown ignores `code_i`. From edge E+2 it gives `high_conn_o`=1, `shdn_res_o`=0 and no taps for WAKE_CYC cycles. From edge E+2+WAKE_CYC, the tap of the code stored before shutdown is enabled.
- R7: Loads that arrive during the recall period are ignored.
- R8: In shutdown, if `supply_low_i` is high for GLITCH_CYC or more consecutive cycles, the stored code becomes 64. A shorter run leaves the code unchanged.
- R9: Outside shutdown, `supply_low_i` has no effect.
- R10: A load with a new code during an overlap restarts the overlap. The previous target tap stays enabled beside the latest target for MOVE_CYC cycles.
- R11: While the high end stays connected, every change of the tap enables keeps at least one tap closed across the change (make-before-break).
- R12: No more than two tap enables are ever high. No tap is enabled while `high_conn_o` is 0, and `shdn_res_o` is never high together with `high_conn_o` or any tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle load strobe from the end of a serial write |
| code_i | input | 7 | Wiper code carried by the load |
| run_i | input | 1 | Run bit carried by the load; 0 requests shutdown |
| supply_low_i | input | 1 | Supply-below-threshold flag |
| tap_en_o | output | 128 | Tap switch enables, bit k is tap k |
| high_conn_o | output | 1 | High-end connection enable |
| shdn_res_o | output | 1 | Shutdown resistor enable (wiper to low end) |

## Verification
Every load response is due exactly two edges after the edge that samples the strobe. The first register takes the new state, and the registered output stage shows it one edge later. An overlap lasts MOVE_CYC cycles and a recall lasts WAKE_CYC cycles beyond that point. The driver works out the due cycle of each expected output from the cycle in which it raised the strobe, and places the first and last cycle of each window and the first cycle after it in the scoreboard. A monitor compares each item at the falling edge of the cycle it names, and flags any item that falls behind. A glitch reset is invisible while in shutdown, so it is observed through the tap that returns after a later recall.

// File: rtl/wtap_pkg.sv
package wtap_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_MOVE = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } wtap_state_e;
endpackage

// File: rtl/wtap_glitch_filt.sv
module wtap_glitch_filt #(
  parameter int HOLD = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic low_i,
  output logic trip_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm_i || !low_i) begin
      run_cnt <= '0;
    end else if (run_cnt != TOP) begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

  // fires on the cycle that completes HOLD consecutive low samples
  assign trip_o = arm_i && low_i && (run_cnt == LAST);

  if (HOLD > 1) begin : g_chk
    // R8: a trip is always preceded by an armed low cycle
    a_r8_trip_follows_low: assert property (@(posedge clk) disable iff (rst)
      trip_o |-> ($past(low_i) && $past(arm_i)));
  end
endmodule

// File: rtl/wtap_seq.sv
module wtap_seq
  import wtap_pkg::*;
#(
  parameter int TAPS     = 128,
  parameter int MOVE_CYC = 3,
  parameter int WAKE_CYC = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [$clog2(TAPS)-1:0]   code_i,
  input  logic                      run_i,
  input  logic                      trip_i,
  output wtap_state_e               st_o,
  output logic [$clog2(TAPS)-1:0]   cur_o,
  output logic [$clog2(TAPS)-1:0]   prev_o
);
  localparam int CW   = $clog2(TAPS);
  localparam int TMAX = (MOVE_CYC > WAKE_CYC) ? MOVE_CYC : WAKE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] MID      = CW'(TAPS / 2);
  localparam logic [TW-1:0] MOVE_TOP = TW'(MOVE_CYC - 1);
  localparam logic [TW-1:0] WAKE_TOP = TW'(WAKE_CYC - 1);

  wtap_state_e   st;
  logic [CW-1:0] cur, prev;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_RUN;
      cur  <= MID;
      prev <= MID;
      tmr  <= '0;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (load_i) begin
            if (!run_i) begin
              st <= ST_OFF;
            end else if (code_i != cur) begin
              prev <= cur;
              cur  <= code_i;
              tmr  <= MOVE_TOP;
              st   <= ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          if (load_i && !run_i) begin
            st <= ST_OFF;
          end else if (load_i && (code_i != cur)) begin
            prev <= cur;
            cur  <= code_i;
            tmr  <= MOVE_TOP;
          end else if (tmr == '0) begin
            st <= ST_RUN;
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        ST_OFF: begin
          if (trip_i) cur <= MID;
          if (load_i && run_i) begin
            st  <= ST_WAKE;
            tmr <= WAKE_TOP;
          end
        end
        ST_WAKE: begin
          if (tmr == '0) st <= ST_RUN;
          else           tmr <= tmr - TW'(1);
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign st_o   = st;
  assign cur_o  = cur;
  assign prev_o = prev;

  // R7: recall ignores loads, the stored code cannot move
  a_r7_wake_holds_code: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAKE) |=> $stable(cur));
  // R8: a glitch trip in shutdown leaves mid-scale stored
  a_r8_trip_to_mid: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF && trip_i) |=> (cur == MID));
  // R5: without a trip, shutdown keeps the stored code
  a_r5_off_holds_code: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF && !trip_i) |=> $stable(cur));
endmodule

// File: rtl/wtap_drive.sv
module wtap_drive
  import wtap_pkg::*;
#(
  parameter int TAPS = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  wtap_state_e             st_i,
  input  logic [$clog2(TAPS)-1:0] cur_i,
  input  logic [$clog2(TAPS)-1:0] prev_i,
  output logic [TAPS-1:0]         tap_o,
  output logic                    hi_o,
  output logic                    res_o
);
  localparam int CW  = $clog2(TAPS);
  localparam int MID = TAPS / 2;
  localparam logic [TAPS-1:0] MID_HOT = {{(TAPS-1){1'b0}}, 1'b1} << MID;

  logic [TAPS-1:0] hot_cur, hot_prev;

  for (genvar g = 0; g < TAPS; g++) begin : g_dec
    assign hot_cur[g]  = (cur_i  == CW'(g));
    assign hot_prev[g] = (prev_i == CW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_o <= MID_HOT;
      hi_o  <= 1'b1;
      res_o <= 1'b0;
    end else begin
      unique case (st_i)
        ST_RUN:  begin tap_o <= hot_cur;            hi_o <= 1'b1; res_o <= 1'b0; end
        ST_MOVE: begin tap_o <= hot_cur | hot_prev; hi_o <= 1'b1; res_o <= 1'b0; end
        ST_OFF:  begin tap_o <= '0;                 hi_o <= 1'b0; res_o <= 1'b1; end
        ST_WAKE: begin tap_o <= '0;                 hi_o <= 1'b1; res_o <= 1'b0; end
        default: begin tap_o <= '0;                 hi_o <= 1'b0; res_o <= 1'b1; end
      endcase
    end
  end

  // R11: each change while connected keeps a closed tap across it
  a_r11_make_before_break: assert property (@(posedge clk) disable iff (rst)
    (hi_o && $past(hi_o) && ($past(tap_o) != '0)) |-> ((tap_o & $past(tap_o)) != '0));
  // R6: the high end is connected before a tap closes
  a_r6_high_first: assert property (@(posedge clk) disable iff (rst)
    (($past(tap_o) == '0) && (tap_o != '0)) |-> $past(hi_o));
  // R12: at most two taps, none without the high end, resistor exclusive
  a_r12_two_max: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_o) <= 2);
  a_r12_res_exclusive: assert property (@(posedge clk) disable iff (rst)
    res_o |-> (!hi_o && (tap_o == '0)));
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wtap_pkg::*;
#(
  parameter int TAPS       = 128,
  parameter int MOVE_CYC   = 3,
  parameter int WAKE_CYC   = 8,
  parameter int GLITCH_CYC = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic [$clog2(TAPS)-1:0] code_i,
  input  logic                    run_i,
  input  logic                    supply_low_i,
  output logic [TAPS-1:0]         tap_en_o,
  output logic                    high_conn_o,
  output logic                    shdn_res_o
);
  localparam int CW = $clog2(TAPS);

  wtap_state_e   st;
  logic [CW-1:0] cur, prev;
  logic          trip, arm;

  assign arm = (st == ST_OFF);

  wtap_glitch_filt #(.HOLD(GLITCH_CYC)) u_filt (
    .clk(clk), .rst(rst), .arm_i(arm), .low_i(supply_low_i), .trip_o(trip)
  );

  wtap_seq #(.TAPS(TAPS), .MOVE_CYC(MOVE_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .code_i(code_i), .run_i(run_i),
    .trip_i(trip), .st_o(st), .cur_o(cur), .prev_o(prev)
  );

  wtap_drive #(.TAPS(TAPS)) u_drive (
    .clk(clk), .rst(rst), .st_i(st), .cur_i(cur), .prev_i(prev),
    .tap_o(tap_en_o), .hi_o(high_conn_o), .res_o(shdn_res_o)
  );
endmodule

// File: tb/sim_wiper_tap_ctrl.sv
module sim_wiper_tap_ctrl;
  localparam int TAPS = 128;
  localparam int MV   = 3;
  localparam int WK   = 8;
  localparam int GL   = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst, load_i, run_i, supply_low_i;
  logic [6:0]      code_i;
  logic [TAPS-1:0] tap_en_o;
  logic            high_conn_o, shdn_res_o;

  wiper_tap_ctrl #(.TAPS(TAPS), .MOVE_CYC(MV), .WAKE_CYC(WK), .GLITCH_CYC(GL)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .code_i(code_i), .run_i(run_i),
    .supply_low_i(supply_low_i), .tap_en_o(tap_en_o),
    .high_conn_o(high_conn_o), .shdn_res_o(shdn_res_o)
  );

  typedef struct {
    int              at;
    logic [TAPS-1:0] tap;
    logic            hi;
    logic            res;
    string           tag;
  } exp_t;

  exp_t q[$];
  exp_t m_e;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  int   pos;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [TAPS-1:0] hot(int k);
    logic [TAPS-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic push(int at, logic [TAPS-1:0] t, logic h, logic r, string tag);
    exp_t e;
    e.at = at; e.tap = t; e.hi = h; e.res = r; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare every due item at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      m_e = q.pop_front();
      checks++;
      if (m_e.at != cyc || tap_en_o !== m_e.tap || high_conn_o !== m_e.hi ||
          shdn_res_o !== m_e.res) begin
        errors++;
        $display("FAIL %s: cycle %0d tap=%h hi=%b res=%b, expected cycle %0d tap=%h hi=%b res=%b",
                 m_e.tag, cyc, tap_en_o, high_conn_o, shdn_res_o,
                 m_e.at, m_e.tap, m_e.hi, m_e.res);
      end
    end
  end

  task automatic settle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_load(int code, logic run, output int n);
    @(negedge clk);
    n = cyc;
    code_i = 7'(code);
    run_i = run;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic move_to(int code, string tag);
    int n;
    do_load(code, 1'b1, n);
    push(n + 2, hot(code) | hot(pos), 1'b1, 1'b0, {tag, " R11 overlap first"});
    push(n + 1 + MV, hot(code) | hot(pos), 1'b1, 1'b0, {tag, " overlap last"});
    push(n + 2 + MV, hot(code), 1'b1, 1'b0, {tag, " settled"});
    pos = code;
    settle(MV + 4);
  endtask

  task automatic go_off(string tag);
    int n;
    do_load(3, 1'b0, n);
    push(n + 2, '0, 1'b0, 1'b1, {tag, " R12 shutdown outputs"});
    settle(4);
  endtask

  task automatic go_on(string tag);
    int n;
    do_load(99, 1'b1, n);
    push(n + 2, '0, 1'b1, 1'b0, {tag, " recall first"});
    push(n + 1 + WK, '0, 1'b1, 1'b0, {tag, " recall last"});
    push(n + 2 + WK, hot(pos), 1'b1, 1'b0, {tag, " restored"});
    settle(WK + 4);
  endtask

  initial begin
    int n;
    rst = 1'b1; load_i = 1'b0; run_i = 1'b1; code_i = '0; supply_low_i = 1'b0;
    pos = 64;
    settle(3);
    rst = 1'b0;
    push(cyc + 1, hot(64), 1'b1, 1'b0, "R1 reset state");
    settle(3);

    move_to(100, "R2 up");
    move_to(0, "R2 low end");
    move_to(127, "R2 high end");

    // R3: same code, no overlap
    do_load(127, 1'b1, n);
    push(n + 2, hot(127), 1'b1, 1'b0, "R3 same code");
    push(n + 3, hot(127), 1'b1, 1'b0, "R3 same code later");
    settle(5);

    // R4: inputs move without a strobe
    @(negedge clk);
    n = cyc;
    code_i = 7'd3; run_i = 1'b0;
    push(n + 2, hot(127), 1'b1, 1'b0, "R4 no strobe");
    push(n + 6, hot(127), 1'b1, 1'b0, "R4 no strobe later");
    settle(7);
    run_i = 1'b1;

    // R10: back-to-back loads during overlap
    @(negedge clk);
    n = cyc;
    code_i = 7'd10; load_i = 1'b1;
    @(negedge clk);
    code_i = 7'd20;
    @(negedge clk);
    load_i = 1'b0;
    push(n + 2, hot(10) | hot(127), 1'b1, 1'b0, "R10 first overlap");
    push(n + 3, hot(20) | hot(10), 1'b1, 1'b0, "R10 restarted overlap");
    push(n + 2 + MV, hot(20) | hot(10), 1'b1, 1'b0, "R10 restarted overlap last");
    push(n + 3 + MV, hot(20), 1'b1, 1'b0, "R10 settled");
    pos = 20;
    settle(MV + 5);

    // R5: shutdown, and a second off-load is ignored
    go_off("R5 enter");
    do_load(33, 1'b0, n);
    push(n + 3, '0, 1'b0, 1'b1, "R5 off-load ignored");
    settle(3);
    // R6: recall restores stored code, ignores code_i
    go_on("R6 exit");

    // R7: load during recall ignored
    go_off("R7 enter");
    do_load(99, 1'b1, n);
    push(n + 2, '0, 1'b1, 1'b0, "R7 recall first");
    push(n + 1 + WK, '0, 1'b1, 1'b0, "R7 recall last");
    push(n + 2 + WK, hot(pos), 1'b1, 1'b0, "R7 restored after ignored load");
    do_load(50, 1'b0, n);
    settle(WK + 4);

    // R8: short supply dip keeps code
    go_off("R8 short");
    supply_low_i = 1'b1;
    settle(GL - 1);
    supply_low_i = 1'b0;
    settle(3);
    go_on("R8 short dip keeps code");

    // R8: long supply dip forces mid-scale
    go_off("R8 long");
    supply_low_i = 1'b1;
    settle(GL);
    supply_low_i = 1'b0;
    settle(3);
    pos = 64;
    go_on("R8 long dip mid-scale");

    // R9: supply dip in normal mode has no effect
    move_to(90, "R9 prep");
    @(negedge clk);
    n = cyc;
    supply_low_i = 1'b1;
    push(n + 3, hot(90), 1'b1, 1'b0, "R9 low outside shutdown");
    push(n + GL + 4, hot(90), 1'b1, 1'b0, "R9 low outside shutdown later");
    settle(GL + 6);
    supply_low_i = 1'b0;
    move_to(91, "R9 still moves");

    wait (q.size() == 0);
    settle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: all requirements, actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule